// File: doc/BRIEF.md
# Hash Store and Check Execution Unit

This unit executes two instructions that protect stored return addresses. Store-hash computes a 64-bit digest from two register values and a secret 64-bit key, then writes that digest to memory. Check-hash computes the same digest, reads the doubleword at the same kind of address, and signals a program trap when the two differ. Software stores a digest on function entry and checks it before return, so a corrupted saved value is caught.

The target address is the RA register value plus a negative, doubleword-aligned offset. The offset is built from a 6-bit displacement that is split across the instruction word. The digest comes from four parallel lanes of a 32-round, 16-bit-word Feistel cipher. All four lanes share one on-the-fly key schedule, and each lane reads it with its own rotation. The unit accepts one instruction at a time through a valid pulse. It drives a single-beat 64-bit memory request that is held until acknowledged. It reports completion, trap and invalid-form pulses.

Top module: `hash_guard_unit`

## Requirements
- R1: After reset, `busy`, `done`, `trap`, `illegal`, `mem_req` and `mem_we` are all 0.
- R2: An instruction is recognised when bits 31:26 equal 31 and bits 10:1 equal 1011010010 (store-hash) or 1011110010 (check-hash). The RA field is bits 20:16.
- R3: The displacement is {bit 0, bits 25:21}, 6 bits. The offset is 0xFFFF_FFFF_FFFF_FE00 with the displacement placed in bits 8:3, so it runs from -512 to -8 in steps of 8. The memory address is `op_ra` plus the offset, modulo 2^64.
- R4: When `isa_ok` is 1 and the RA field is 0, `illegal` and `done` pulse on the edge that accepts the instruction, and no memory request is made.
- R5: The digest is built as follows. The bytes of RA and RB are interleaved into two 64-bit words H and L:
  - H byte 2i is RA byte 4+i, and H byte 7-2i is RB byte i, for i = 0..3.
  - L byte 2i is RA byte i, and L byte 7-2i is RB byte 4+i.
  - The 32-bit halves H-high, H-low, L-high and L-low go through the cipher with key rotations 0, 1, 2 and 3.
  - The digest is {c0, c1} XOR {c2, c3}.

  Store-hash writes this digest with `mem_we` = 1.
- R6: Check-hash issues a read (`mem_we` = 0) and raises `trap` with `done` exactly when `mem_rdata` differs from the digest. A store followed by a check with the same operands does not trap, and a single flipped bit does.
- R7: `trap` and `illegal` are only ever high in a cycle where `done` is high, and never both at once.
- R8: When `isa_ok` is 0, an accepted instruction completes as a no-op: `done` pulses on the accepting edge, with no request and no exception.
- R9: The memory request rises on the 33rd clock edge after the accepting edge. `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ack`. `done` pulses on the edge that samples `mem_ack`.
- R10: A word that matches neither encoding completes as a no-op, in the same way as R8.
- R11: `op_valid` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction presented |
| op_instr | input | 32 | Decoded instruction word |
| op_ra | input | 64 | Value of register RA |
| op_rb | input | 64 | Value of register RB |
| hash_key | input | 64 | Secret hash key |
| isa_ok | input | 1 | ISA level implements these instructions |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| trap | output | 1 | Program trap pulse (check mismatch) |
| illegal | output | 1 | Invalid-form pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Request address |
| mem_wdata | output | 64 | Write data (digest) |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
A wrong round counter or key-group step inside the digest core would show at the ports in two ways. `mem_wdata` would differ from the behavioural cipher in the bench, and the request edge would move from its fixed 33-edge latency; both show up on the first store. A stale digest or a wrong direction flag would show on the following check, as a trap on a matching value or a silence on a single-bit corruption. A decode fault would show within one cycle as a misplaced `done`, a missing `illegal`, or an unexpected request.

// File: rtl/hash_guard_pkg.sv
package hash_guard_pkg;
    localparam int XLEN   = 64;
    localparam int HWORD  = 16;
    localparam int LANES  = 4;
    localparam int KWORDS = 4;
    localparam int ROUNDS = 32;
    localparam int RND_W  = $clog2(ROUNDS + 1);
    localparam int GRP_W  = $clog2(ROUNDS / KWORDS);

    localparam logic [5:0]      PRIMARY_OP = 6'd31;
    localparam logic [9:0]      XO_STORE   = 10'b1011010010;
    localparam logic [9:0]      XO_CHECK   = 10'b1011110010;
    localparam logic [XLEN-1:0] OFF_BASE   = 64'hFFFF_FFFF_FFFF_FE00;
    localparam logic [HWORD-1:0] KS_CONST  = 16'hfffc;
    localparam logic [63:0]     KS_SEQ     = 64'hfa2561cdf44ac398;

    typedef logic [HWORD-1:0] hword_t;
    typedef enum logic [1:0] {ST_IDLE, ST_HASH, ST_MEM} unit_st_e;

    function automatic hword_t rol16(hword_t x, int unsigned n);
        return (x << n) | (x >> (HWORD - n));
    endfunction

    function automatic hword_t ror16(hword_t x, int unsigned n);
        return (x >> n) | (x << (HWORD - n));
    endfunction
endpackage

// File: rtl/hash_key_step.sv
module hash_key_step
    import hash_guard_pkg::*;
(
    input  logic [KWORDS-1:0][HWORD-1:0] grp_i,
    input  logic [GRP_W-1:0]             grp_idx_i,
    output logic [KWORDS-1:0][HWORD-1:0] grp_o
);
    logic [2*KWORDS-1:0][HWORD-1:0] win;
    logic [KWORDS-1:0][HWORD-1:0]   tmp;

    always_comb begin
        win = '0;
        tmp = '0;
        for (int m = 0; m < KWORDS; m++) win[m] = grp_i[m];
        for (int m = 0; m < KWORDS; m++) begin
            int zi;
            zi = int'(grp_idx_i) * KWORDS + m;
            tmp[m] = ror16(win[m+3], 3) ^ win[m+1];
            win[m+4] = KS_CONST ^ {15'b0, KS_SEQ[6'(63 - zi)]} ^ win[m]
                       ^ tmp[m] ^ ror16(tmp[m], 1);
        end
        for (int m = 0; m < KWORDS; m++) grp_o[m] = win[m+KWORDS];
    end
endmodule

// File: rtl/hash_round.sv
module hash_round
    import hash_guard_pkg::*;
(
    input  hword_t lft_i,
    input  hword_t rgt_i,
    input  hword_t key_i,
    output hword_t lft_o,
    output hword_t rgt_o
);
    hword_t mix;
    always_comb begin
        mix   = (rol16(lft_i, 1) & rol16(lft_i, 8)) ^ rol16(lft_i, 2);
        lft_o = rgt_i ^ mix ^ key_i;
        rgt_o = lft_i;
    end
endmodule

// File: rtl/hash_digest_core.sv
module hash_digest_core
    import hash_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] ra_i,
    input  logic [XLEN-1:0] rb_i,
    input  logic [XLEN-1:0] key_i,
    output logic            busy_o,
    output logic            valid_o,
    output logic [XLEN-1:0] digest_o
);
    typedef struct packed {
        logic                          run;
        logic                          vld;
        logic [RND_W-1:0]              rnd;
        logic [LANES-1:0][HWORD-1:0]   lft;
        logic [LANES-1:0][HWORD-1:0]   rgt;
        logic [KWORDS-1:0][HWORD-1:0]  grp;
    } core_s;

    core_s q, d;

    logic [XLEN-1:0]               mix_h, mix_l;
    logic [LANES-1:0][31:0]        lane_in;
    logic [LANES-1:0][HWORD-1:0]   nxt_lft, nxt_rgt;
    logic [KWORDS-1:0][HWORD-1:0]  grp_next;
    logic [LANES-1:0][31:0]        lane_out;

    // byte interleave of the two operands
    always_comb begin
        mix_h = '0;
        mix_l = '0;
        for (int i = 0; i < 4; i++) begin
            mix_h[8*(7-2*i) +: 8] = rb_i[8*i +: 8];
            mix_h[8*(2*i)   +: 8] = ra_i[32 + 8*i +: 8];
            mix_l[8*(7-2*i) +: 8] = rb_i[32 + 8*i +: 8];
            mix_l[8*(2*i)   +: 8] = ra_i[8*i +: 8];
        end
        lane_in[0] = mix_h[63:32];
        lane_in[1] = mix_h[31:0];
        lane_in[2] = mix_l[63:32];
        lane_in[3] = mix_l[31:0];
    end

    hash_key_step u_ks (
        .grp_i     (q.grp),
        .grp_idx_i (q.rnd[RND_W-2:2]),
        .grp_o     (grp_next)
    );

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [1:0] sel;
        assign sel = q.rnd[1:0] + 2'(L);
        hash_round u_rnd (
            .lft_i (q.lft[L]),
            .rgt_i (q.rgt[L]),
            .key_i (q.grp[sel]),
            .lft_o (nxt_lft[L]),
            .rgt_o (nxt_rgt[L])
        );
        assign lane_out[L] = {q.rgt[L], q.lft[L]};
    end

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (start_i) begin
            d.run = 1'b1;
            d.rnd = '0;
            for (int L = 0; L < LANES; L++) begin
                d.lft[L] = lane_in[L][15:0];
                d.rgt[L] = lane_in[L][31:16];
            end
            for (int m = 0; m < KWORDS; m++) d.grp[m] = key_i[XLEN-1-HWORD*m -: HWORD];
        end else if (q.run) begin
            d.lft = nxt_lft;
            d.rgt = nxt_rgt;
            if (q.rnd[1:0] == 2'd3) d.grp = grp_next;
            d.rnd = q.rnd + 1'b1;
            if (q.rnd == RND_W'(ROUNDS - 1)) begin
                d.run = 1'b0;
                d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o   = q.run;
    assign valid_o  = q.vld;
    assign digest_o = {lane_out[0], lane_out[1]} ^ {lane_out[2], lane_out[3]};

    // R9
    round_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.rnd < RND_W'(ROUNDS)));
    // R9
    valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> !q.run);
endmodule

// File: rtl/hash_decode.sv
module hash_decode
    import hash_guard_pkg::*;
(
    input  logic [31:0]     instr_i,
    output logic            is_store_o,
    output logic            is_check_o,
    output logic            ra_zero_o,
    output logic [XLEN-1:0] offset_o
);
    logic       prim_hit;
    logic [5:0] disp;
    logic       unused_rb;

    assign prim_hit   = (instr_i[31:26] == PRIMARY_OP);
    assign is_store_o = prim_hit && (instr_i[10:1] == XO_STORE);
    assign is_check_o = prim_hit && (instr_i[10:1] == XO_CHECK);
    assign ra_zero_o  = (instr_i[20:16] == 5'd0);
    assign disp       = {instr_i[0], instr_i[25:21]};
    assign offset_o   = OFF_BASE | {55'b0, disp, 3'b000};
    assign unused_rb  = ^instr_i[15:11];
endmodule

// File: rtl/hash_guard_unit.sv
module hash_guard_unit
    import hash_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [31:0] op_instr,
    input  logic [63:0] op_ra,
    input  logic [63:0] op_rb,
    input  logic [63:0] hash_key,
    input  logic        isa_ok,
    output logic        busy,
    output logic        done,
    output logic        trap,
    output logic        illegal,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [63:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [63:0] mem_rdata
);
    typedef struct packed {
        unit_st_e        st;
        logic            chk;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] dig;
        logic            req;
        logic            done;
        logic            trap;
        logic            ill;
    } unit_s;

    unit_s q, d;

    logic            dec_store, dec_check, dec_ra_zero;
    logic [XLEN-1:0] dec_offset;
    logic            core_start, core_busy, core_valid;
    logic [XLEN-1:0] core_digest;

    hash_decode u_dec (
        .instr_i    (op_instr),
        .is_store_o (dec_store),
        .is_check_o (dec_check),
        .ra_zero_o  (dec_ra_zero),
        .offset_o   (dec_offset)
    );

    hash_digest_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (core_start),
        .ra_i     (op_ra),
        .rb_i     (op_rb),
        .key_i    (hash_key),
        .busy_o   (core_busy),
        .valid_o  (core_valid),
        .digest_o (core_digest)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.trap     = 1'b0;
        d.ill      = 1'b0;
        core_start = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    if (!isa_ok || !(dec_store || dec_check)) begin
                        d.done = 1'b1;
                    end else if (dec_ra_zero) begin
                        d.done = 1'b1;
                        d.ill  = 1'b1;
                    end else begin
                        core_start = 1'b1;
                        d.st   = ST_HASH;
                        d.chk  = dec_check;
                        d.addr = op_ra + dec_offset;
                    end
                end
            end
            ST_HASH: begin
                if (core_valid) begin
                    d.dig = core_digest;
                    d.req = 1'b1;
                    d.st  = ST_MEM;
                end
            end
            ST_MEM: begin
                if (mem_ack) begin
                    d.req  = 1'b0;
                    d.done = 1'b1;
                    d.trap = q.chk && (mem_rdata != q.dig);
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign trap      = q.trap;
    assign illegal   = q.ill;
    assign mem_req   = q.req;
    assign mem_we    = q.req && !q.chk;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.dig;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R9
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (done && !mem_req));
    // R7
    trap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (done && !illegal));
    // R4
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !mem_req && !busy));
    // R8
    nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && !isa_ok) |=> (done && !mem_req && !illegal && !trap));
    // R9
    hash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |-> (busy && !mem_req));
endmodule

// File: tb/hash_guard_unit_tb.sv
module hash_guard_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_instr = '0;
    logic [63:0] op_ra = '0, op_rb = '0, hash_key = '0;
    logic        isa_ok = 1'b1;
    logic        busy, done, trap, illegal, mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int ack_delay = 0, wait_cnt = 0;
    logic [63:0] mem [logic [63:0]];

    always #4 clk = ~clk;

    hash_guard_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_instr(op_instr),
        .op_ra(op_ra), .op_rb(op_rb), .hash_key(hash_key), .isa_ok(isa_ok),
        .busy(busy), .done(done), .trap(trap), .illegal(illegal),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= ack_delay) begin
                mem_ack  <= 1'b1;
                wait_cnt <= 0;
                if (mem_we) mem[mem_addr] = mem_wdata;
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rl(logic [15:0] x, int n);
        return (x << n) | (x >> (16 - n));
    endfunction

    function automatic logic [31:0] ref_cipher(logic [31:0] x, logic [63:0] key, int lane);
        logic [15:0] k [32];
        logic [15:0] l, r, t, f, nl;
        logic [63:0] zs = 64'hfa2561cdf44ac398;
        for (int i = 0; i < 4; i++) k[3-i] = key[16*i +: 16];
        for (int i = 0; i < 28; i++) begin
            t = rl(k[i+3], 13) ^ k[i+1];
            k[i+4] = 16'hfffc ^ {15'b0, zs[63-i]} ^ k[i] ^ t ^ rl(t, 15);
        end
        l = x[15:0];
        r = x[31:16];
        for (int i = 0; i < 32; i++) begin
            f  = (rl(l, 1) & rl(l, 8)) ^ rl(l, 2);
            nl = r ^ f ^ k[4*(i/4) + ((i%4 + lane) % 4)];
            r  = l;
            l  = nl;
        end
        return {r, l};
    endfunction

    function automatic logic [63:0] ref_digest(logic [63:0] ra, logic [63:0] rb, logic [63:0] key);
        logic [63:0] h = '0, lo = '0;
        for (int i = 0; i < 4; i++) begin
            h  |= {56'b0, rb[8*i +: 8]} << (8*(7-2*i));
            h  |= {56'b0, ra[32+8*i +: 8]} << (16*i);
            lo |= {56'b0, rb[32+8*i +: 8]} << (8*(7-2*i));
            lo |= {56'b0, ra[8*i +: 8]} << (16*i);
        end
        return {ref_cipher(h[63:32], key, 0), ref_cipher(h[31:0], key, 1)}
             ^ {ref_cipher(lo[63:32], key, 2), ref_cipher(lo[31:0], key, 3)};
    endfunction

    function automatic logic [31:0] mk(bit chk, logic [4:0] raf, logic [5:0] dw);
        return {6'd31, dw[4:0], raf, 5'd7, chk ? 10'b1011110010 : 10'b1011010010, dw[5]};
    endfunction

    function automatic logic [63:0] offs(logic [5:0] dw);
        return 64'hFFFF_FFFF_FFFF_FE00 | ({58'b0, dw} << 3);
    endfunction

    // results of last op
    bit          r_req;
    int          r_req_n, r_done_n;
    logic [63:0] r_addr, r_wdata;
    logic        r_we, r_trap, r_ill;

    task automatic run_op(input logic [31:0] ins, input logic [63:0] ra, input logic [63:0] rb,
                          input logic [63:0] key, input logic isa, input bit poke);
        int n;
        @(negedge clk);
        op_valid = 1'b1; op_instr = ins; op_ra = ra; op_rb = rb; hash_key = key; isa_ok = isa;
        r_req = 0; r_req_n = 0; r_trap = 0; r_ill = 0; r_done_n = 0;
        r_addr = '0; r_wdata = '0; r_we = 0;
        @(negedge clk);
        op_valid = 1'b0;
        n = 1;
        forever begin
            // per-cycle comparison with the model: exceptions only with completion
            if ((trap || illegal) && !done)
                check(0, "R7 exception without done", {62'b0, trap, illegal}, 64'd0);
            if (n == 5 && poke) begin
                op_valid = 1'b1;
                op_instr = mk(0, 5'd3, 6'd0);
                op_ra    = 64'h1234;
            end else begin
                op_valid = 1'b0;
            end
            if (mem_req && !r_req) begin
                r_req = 1; r_req_n = n; r_addr = mem_addr; r_we = mem_we; r_wdata = mem_wdata;
            end
            if (done) begin
                r_trap = trap; r_ill = illegal; r_done_n = n;
                break;
            end
            if (n > 200) begin
                check(0, "op did not complete", 64'(n), 64'd0);
                break;
            end
            n++;
            @(negedge clk);
        end
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] ra, rb, key, dg, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check({busy, done, trap, illegal, mem_req, mem_we} == 6'b0, "R1 reset outputs",
              {58'b0, busy, done, trap, illegal, mem_req, mem_we}, 64'd0);

        // store then check, same operands
        ra = 64'h0000_7fff_ffff_e010; rb = 64'h0123_4567_89ab_cdef; key = 64'h0f1e_2d3c_4b5a_6978;
        dg = ref_digest(ra, rb, key);
        a  = ra + offs(6'd21);
        ack_delay = 2;
        run_op(mk(0, 5'd1, 6'd21), ra, rb, key, 1'b1, 0);
        check(r_req && r_we, "R2 store issues write", {63'b0, r_we}, 64'd1);
        check(r_addr == a, "R3 store address", r_addr, a);
        check(r_wdata == dg, "R5 store digest", r_wdata, dg);
        check(r_req_n == 34, "R9 request latency", 64'(r_req_n), 64'd34);
        check(r_done_n == r_req_n + 3, "R9 done after ack", 64'(r_done_n), 64'(r_req_n + 3));
        check(!r_trap && !r_ill, "R7 store no exception", {62'b0, r_trap, r_ill}, 64'd0);

        ack_delay = 0;
        run_op(mk(1, 5'd1, 6'd21), ra, rb, key, 1'b1, 0);
        check(r_req && !r_we && r_addr == a, "R6 check reads address", r_addr, a);
        check(!r_trap, "R6 matching check no trap", {63'b0, r_trap}, 64'd0);

        // single bit corruption
        mem[a] = mem[a] ^ 64'h0000_0100_0000_0000;
        run_op(mk(1, 5'd1, 6'd21), ra, rb, key, 1'b1, 0);
        check(r_trap, "R6 corrupted bit traps", {63'b0, r_trap}, 64'd1);

        // displacement extremes
        ra = 64'h0000_0000_0000_0100; rb = 64'hffff_0000_1111_2222; key = 64'hdead_beef_0bad_f00d;
        ack_delay = 1;
        run_op(mk(0, 5'd31, 6'd0), ra, rb, key, 1'b1, 0);
        check(r_addr == ra - 64'd512, "R3 offset -512", r_addr, ra - 64'd512);
        check(r_wdata == ref_digest(ra, rb, key), "R5 digest second pattern", r_wdata, ref_digest(ra, rb, key));
        run_op(mk(0, 5'd31, 6'd63), ra, rb, key, 1'b1, 0);
        check(r_addr == ra - 64'd8, "R3 offset -8", r_addr, ra - 64'd8);

        // check with a different key traps
        run_op(mk(1, 5'd31, 6'd63), ra, rb, 64'hdead_beef_0bad_f00c, 1'b1, 0);
        check(r_trap, "R5 key change traps", {63'b0, r_trap}, 64'd1);
        // same key, different RB traps
        run_op(mk(1, 5'd31, 6'd63), ra, rb ^ 64'd1, key, 1'b1, 0);
        check(r_trap, "R6 operand change traps", {63'b0, r_trap}, 64'd1);

        // RA field zero
        run_op(mk(0, 5'd0, 6'd5), ra, rb, key, 1'b1, 0);
        check(r_ill && !r_req && r_done_n == 1, "R4 invalid form",
              {62'b0, r_ill, r_req}, 64'd2);

        // ISA level off: no-op, even with RA field zero
        run_op(mk(1, 5'd0, 6'd5), ra, rb, key, 1'b0, 0);
        check(!r_ill && !r_req && !r_trap && r_done_n == 1, "R8 isa off no-op",
              {61'b0, r_ill, r_req, r_trap}, 64'd0);

        // unknown extended opcode
        run_op({6'd31, 5'd1, 5'd2, 5'd3, 10'b1011010011, 1'b0}, ra, rb, key, 1'b1, 0);
        check(!r_req && !r_ill && r_done_n == 1, "R10 other word no-op", {62'b0, r_req, r_ill}, 64'd0);
        run_op({6'd30, 5'd1, 5'd2, 5'd3, 10'b1011010010, 1'b0}, ra, rb, key, 1'b1, 0);
        check(!r_req && r_done_n == 1, "R2 wrong primary opcode", {63'b0, r_req}, 64'd0);

        // new op while busy is ignored
        ra = 64'h0000_0000_0040_0000;
        run_op(mk(0, 5'd9, 6'd33), ra, rb, key, 1'b1, 1);
        check(r_addr == ra + offs(6'd33), "R11 busy ignores op_valid", r_addr, ra + offs(6'd33));
        check(r_wdata == ref_digest(ra, rb, key), "R11 digest unchanged", r_wdata, ref_digest(ra, rb, key));
        @(negedge clk);
        check(!busy && !mem_req, "R11 idle after op", {62'b0, busy, mem_req}, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule